// File: doc/BRIEF.md
# Code Density Histogram Engine

This block builds a histogram of converter output codes during a linearity test. While a precisely known ramp or sinewave drives the converter under test, every valid output code is counted in its own bin. The total number of accepted samples is counted as well. The acquisition stops once a programmed sample budget M has been collected. After that, any bin can be read back together with a flag that marks a code that never appeared. In ramp mode the readout also carries a fixed-point estimate of that code's differential non-linearity.

A run begins with a start pulse. The pulse latches the sample budget, the number of stimulus periods P and the stimulus kind, and then wipes every bin in a sequential pass. The engine checks the coherent-sampling setup it is given. An even P, or a stimulus frequency P/M·fs at or above half the sample rate, raises a parameter error. For sinewave stimuli the arcsine correction and the floating-point linearity figures are left to software, which reads the raw counts. In ramp mode the two end codes collect overload hits, so they are kept out of the average bin size.

Top module: `code_hist_engine`

## Requirements
- R1: A start pulse clears every bin in one pass of 2^CODE_W cycles. During the pass `ready` and `done` are low. `ready` rises exactly 2^CODE_W cycles after the start edge, and counts left over from an earlier run read back as zero.
- R2: Each sample accepted while `ready` is high adds one to the bin of its code. This holds for consecutive samples of the same code in back-to-back cycles.
- R3: `total_cnt` rises by one for each accepted sample and is zero after a start.
- R4: When the accepted count reaches the budget M, `ready` falls after that edge and `done` rises one cycle later. `done` stays high until the next start, and `total_cnt` never exceeds M.
- R5: With a budget of zero, `done` rises right at the end of the clear pass, and every bin reads zero.
- R6: `rd_en` is served only while `done` is high and no read is in progress. A served read gives one `rd_valid` pulse carrying the count for `rd_addr`. A request made at any other time produces no `rd_valid`.
- R7: `rd_missing` is high exactly when the returned count is zero.
- R8: At each start, `param_err` is set to 1 if P is even, or if M is non-zero and 2·P ≥ M. Otherwise it is 0. It holds that value until the next start.
- R9: In ramp mode, for codes 1 to 2^CODE_W−2, `rd_dnl` equals floor(count·(2^CODE_W−2)·2^FRAC_W / D) − 2^FRAC_W, signed, clipped at the largest positive value. Here D = total − count(code 0) − count(top code). End codes read a DNL of 0, and in sinewave mode every DNL reads 0.
- R10: If D is zero in ramp mode, `rd_dnl` is 0 for every code.
- R11: Samples with `smp_valid` low, and samples offered while `ready` is low, leave all bins and `total_cnt` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a run: latches settings and clears the bins |
| budget_m | input | CNT_W | Sample budget M |
| periods_p | input | P_W | Stimulus periods P in the record |
| ramp_mode | input | 1 | 1 = ramp stimulus (DNL computed), 0 = sinewave |
| smp_valid | input | 1 | Sample strobe |
| smp_code | input | CODE_W | Converter output code |
| ready | output | 1 | Samples are being accepted |
| done | output | 1 | Budget reached; readout available |
| param_err | output | 1 | Coherent-sampling setup rejected |
| total_cnt | output | CNT_W | Samples accepted in this run |
| rd_en | input | 1 | Readout request |
| rd_addr | input | CODE_W | Code to read |
| rd_valid | output | 1 | One-cycle pulse: readout fields valid |
| rd_count | output | CNT_W | Hit count of the addressed code |
| rd_missing | output | 1 | Addressed code never occurred |
| rd_dnl | output | DNL_W | Signed DNL estimate, FRAC_W fraction bits |

## Verification
A bin corrupted by a lost forwarding path or a skipped clear stays hidden until the readout after `done`. There it shows up as a wrong `rd_count`, a wrong missing flag and a wrong DNL on every affected code. The bench therefore reads every bin after the main run and compares it with its own tally. A wrong sequencer state shows within one cycle of the final sample, as a `ready` or `done` edge in the wrong cycle. A wrong clear length shows as `ready` rising early or late after start. A divider fault is seen only through `rd_dnl`, several dozen cycles after the request.

// File: rtl/hist_pkg.sv
package hist_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CLEAR = 3'd1,
    ST_RUN   = 3'd2,
    ST_DRAIN = 3'd3,
    ST_DONE  = 3'd4
  } hist_state_t;

endpackage

// File: rtl/hist_bin_ram.sv
module hist_bin_ram #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // simple dual port, read-first; suited to block RAM inference
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/hist_seq_ctrl.sv
module hist_seq_ctrl
  import hist_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int CNT_W  = 32,
  parameter int P_W    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CNT_W-1:0]  budget,
  input  logic [P_W-1:0]    periods,
  input  logic              smp_valid,
  input  logic              smp_is_end,
  output hist_state_t       state,
  output logic [CODE_W-1:0] clr_addr,
  output logic              accept,
  output logic [CNT_W-1:0]  total,
  output logic [CNT_W-1:0]  end_total,
  output logic [CNT_W-1:0]  budget_q,
  output logic              param_err
);
  localparam int                CMP_W = CNT_W + P_W + 1;
  localparam logic [CODE_W-1:0] LAST  = '1;

  logic [CNT_W-1:0] total_nx;
  logic             p_even;
  logic             p_fast;

  always_comb begin
    accept   = smp_valid && (state == ST_RUN);
    total_nx = total + 1'b1;
    p_even   = ~periods[0];
    // stimulus at or above half the sample rate: 2P >= M
    p_fast   = (budget != '0) && (CMP_W'({periods, 1'b0}) >= CMP_W'(budget));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      clr_addr  <= '0;
      total     <= '0;
      end_total <= '0;
      budget_q  <= '0;
      param_err <= 1'b0;
    end else if (start) begin
      state     <= ST_CLEAR;
      clr_addr  <= '0;
      total     <= '0;
      end_total <= '0;
      budget_q  <= budget;
      param_err <= p_even | p_fast;
    end else begin
      case (state)
        ST_CLEAR: begin
          clr_addr <= clr_addr + 1'b1;
          if (clr_addr == LAST) state <= (budget_q == '0) ? ST_DONE : ST_RUN;
        end
        ST_RUN: begin
          if (accept) begin
            total <= total_nx;
            if (smp_is_end) end_total <= end_total + 1'b1;
            if (total_nx == budget_q) state <= ST_DRAIN;
          end
        end
        ST_DRAIN: state <= ST_DONE;
        default:  state <= state;
      endcase
    end
  end
endmodule

// File: rtl/hist_dnl_calc.sv
module hist_dnl_calc #(
  parameter int CODE_W = 4,
  parameter int CNT_W  = 32,
  parameter int FRAC_W = 8,
  parameter int DNL_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    go,
  input  logic [CNT_W-1:0]        count,
  input  logic [CNT_W-1:0]        den,
  input  logic                    ramp,
  input  logic                    is_end,
  output logic                    fin,
  output logic signed [DNL_W-1:0] dnl
);
  localparam int               NBINS = 1 << CODE_W;
  localparam int               NUM_W = CNT_W + CODE_W + FRAC_W;
  localparam int               ITW   = $clog2(NUM_W + 1);
  localparam logic [NUM_W-1:0] ONE   = NUM_W'(1 << FRAC_W);
  localparam logic [NUM_W-1:0] LIM   = NUM_W'((1 << (DNL_W - 1)) - 1 + (1 << FRAC_W));
  localparam logic [DNL_W-1:0] MAXP  = DNL_W'((1 << (DNL_W - 1)) - 1);

  logic [NUM_W-1:0] num_sh;
  logic [NUM_W-1:0] quo;
  logic [CNT_W-1:0] rem;
  logic [CNT_W-1:0] den_q;
  logic [ITW-1:0]   iter;
  logic             run;

  logic             bypass;
  logic [NUM_W-1:0] num_init;
  logic [CNT_W:0]   rem_sh;
  logic             take;
  logic [CNT_W-1:0] rem_nx;

  always_comb begin
    bypass   = !ramp || is_end || (den == '0);
    num_init = (NUM_W'(count) * NUM_W'(NBINS - 2)) << FRAC_W;
    rem_sh   = {rem, num_sh[NUM_W-1]};
    take     = rem_sh >= {1'b0, den_q};
    rem_nx   = take ? CNT_W'(rem_sh - {1'b0, den_q}) : rem_sh[CNT_W-1:0];
  end

  // restoring division, one quotient bit per cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      num_sh <= '0;
      quo    <= '0;
      rem    <= '0;
      den_q  <= '0;
      iter   <= '0;
      run    <= 1'b0;
      fin    <= 1'b0;
      dnl    <= '0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        if (bypass) begin
          fin <= 1'b1;
          dnl <= '0;
        end else begin
          run    <= 1'b1;
          iter   <= ITW'(NUM_W);
          num_sh <= num_init;
          rem    <= '0;
          quo    <= '0;
          den_q  <= den;
        end
      end else if (run) begin
        if (iter != '0) begin
          rem    <= rem_nx;
          quo    <= {quo[NUM_W-2:0], take};
          num_sh <= num_sh << 1;
          iter   <= iter - 1'b1;
        end else begin
          run <= 1'b0;
          fin <= 1'b1;
          if (quo > LIM) dnl <= MAXP;
          else           dnl <= DNL_W'(quo - ONE);
        end
      end
    end
  end
endmodule

// File: rtl/code_hist_engine.sv
module code_hist_engine
  import hist_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int CNT_W  = 32,
  parameter int P_W    = 16,
  parameter int FRAC_W = 8,
  parameter int DNL_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [CNT_W-1:0]        budget_m,
  input  logic [P_W-1:0]          periods_p,
  input  logic                    ramp_mode,
  input  logic                    smp_valid,
  input  logic [CODE_W-1:0]       smp_code,
  output logic                    ready,
  output logic                    done,
  output logic                    param_err,
  output logic [CNT_W-1:0]        total_cnt,
  input  logic                    rd_en,
  input  logic [CODE_W-1:0]       rd_addr,
  output logic                    rd_valid,
  output logic [CNT_W-1:0]        rd_count,
  output logic                    rd_missing,
  output logic signed [DNL_W-1:0] rd_dnl
);
  localparam logic [CODE_W-1:0] TOP_CODE = '1;
  localparam logic [CNT_W-1:0]  CNT_MAX  = '1;

  hist_state_t       state;
  logic [CODE_W-1:0] clr_addr;
  logic              accept;
  logic [CNT_W-1:0]  end_total;
  logic [CNT_W-1:0]  budget_lat;
  logic              smp_is_end;

  assign smp_is_end = (smp_code == '0) || (smp_code == TOP_CODE);

  hist_seq_ctrl #(.CODE_W(CODE_W), .CNT_W(CNT_W), .P_W(P_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .budget     (budget_m),
    .periods    (periods_p),
    .smp_valid  (smp_valid),
    .smp_is_end (smp_is_end),
    .state      (state),
    .clr_addr   (clr_addr),
    .accept     (accept),
    .total      (total_cnt),
    .end_total  (end_total),
    .budget_q   (budget_lat),
    .param_err  (param_err)
  );

  assign ready = (state == ST_RUN);
  assign done  = (state == ST_DONE);

  logic ramp_q;
  always_ff @(posedge clk) begin
    if (rst)        ramp_q <= 1'b0;
    else if (start) ramp_q <= ramp_mode;
  end

  // read-modify-write pipeline
  logic              s1_vld;
  logic [CODE_W-1:0] s1_addr;
  logic              fw_vld;
  logic [CODE_W-1:0] fw_addr;
  logic [CNT_W-1:0]  fw_data;
  logic [CNT_W-1:0]  ram_rdata;
  logic [CNT_W-1:0]  base;
  logic [CNT_W-1:0]  bumped;
  logic              clearing;
  logic              ram_we;
  logic [CODE_W-1:0] ram_waddr;
  logic [CNT_W-1:0]  ram_wdata;
  logic [CODE_W-1:0] ram_raddr;

  always_comb begin
    clearing  = (state == ST_CLEAR);
    base      = (fw_vld && fw_addr == s1_addr) ? fw_data : ram_rdata;
    bumped    = (base == CNT_MAX) ? base : base + 1'b1;
    ram_we    = clearing || s1_vld;
    ram_waddr = clearing ? clr_addr : s1_addr;
    ram_wdata = clearing ? '0 : bumped;
    ram_raddr = done ? rd_addr : smp_code;
  end

  always_ff @(posedge clk) begin
    if (rst || start) begin
      s1_vld  <= 1'b0;
      s1_addr <= '0;
      fw_vld  <= 1'b0;
      fw_addr <= '0;
      fw_data <= '0;
    end else begin
      s1_vld  <= accept;
      s1_addr <= smp_code;
      fw_vld  <= s1_vld && !clearing;
      fw_addr <= s1_addr;
      fw_data <= bumped;
    end
  end

  hist_bin_ram #(.ADDR_W(CODE_W), .DATA_W(CNT_W)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (ram_raddr),
    .rdata (ram_rdata)
  );

  // readout
  logic                    rd_busy;
  logic                    rd_fetch;
  logic                    rd_go;
  logic [CODE_W-1:0]       rd_addr_q;
  logic [CNT_W-1:0]        cnt_q;
  logic                    dnl_fin;
  logic signed [DNL_W-1:0] dnl_val;
  logic [CNT_W-1:0]        dnl_den;
  logic                    rd_is_end;

  always_comb begin
    rd_go     = rd_en && done && !rd_busy;
    dnl_den   = total_cnt - end_total;
    rd_is_end = (rd_addr_q == '0) || (rd_addr_q == TOP_CODE);
  end

  hist_dnl_calc #(.CODE_W(CODE_W), .CNT_W(CNT_W), .FRAC_W(FRAC_W), .DNL_W(DNL_W)) u_dnl (
    .clk    (clk),
    .rst    (rst || start),
    .go     (rd_fetch),
    .count  (ram_rdata),
    .den    (dnl_den),
    .ramp   (ramp_q),
    .is_end (rd_is_end),
    .fin    (dnl_fin),
    .dnl    (dnl_val)
  );

  always_ff @(posedge clk) begin
    if (rst || start) begin
      rd_busy    <= 1'b0;
      rd_fetch   <= 1'b0;
      rd_addr_q  <= '0;
      cnt_q      <= '0;
      rd_valid   <= 1'b0;
      rd_count   <= '0;
      rd_missing <= 1'b0;
      rd_dnl     <= '0;
    end else begin
      rd_valid <= 1'b0;
      rd_fetch <= rd_go;
      if (rd_go) begin
        rd_busy   <= 1'b1;
        rd_addr_q <= rd_addr;
      end
      if (rd_fetch) cnt_q <= ram_rdata;
      if (dnl_fin && rd_busy) begin
        rd_valid   <= 1'b1;
        rd_count   <= cnt_q;
        rd_missing <= (cnt_q == '0);
        rd_dnl     <= dnl_val;
        rd_busy    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/code_hist_engine_chk.sv
module code_hist_engine_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             smp_valid,
  input logic             ready,
  input logic             done,
  input logic             rd_valid,
  input logic             param_err,
  input logic [CNT_W-1:0] total_cnt,
  input logic [CNT_W-1:0] budget_q
);
  a_r4_done_excludes_ready: assert property (@(posedge clk) disable iff (rst)
    done |-> !ready);

  a_r3_total_steps: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && ready && !start) |=> total_cnt == $past(total_cnt) + 1'b1);

  a_r4_total_within_budget: assert property (@(posedge clk) disable iff (rst)
    (ready || done) |-> total_cnt <= budget_q);

  a_r4_done_holds: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);

  a_r6_read_only_when_done: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> done);

  a_r1_start_drops_status: assert property (@(posedge clk) disable iff (rst)
    start |=> (!ready && !done && total_cnt == '0));

  a_r8_param_err_stable: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(param_err));

  a_r11_idle_total_hold: assert property (@(posedge clk) disable iff (rst)
    (!smp_valid && !start) |=> $stable(total_cnt));
endmodule

bind code_hist_engine code_hist_engine_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .smp_valid (smp_valid),
  .ready     (ready),
  .done      (done),
  .rd_valid  (rd_valid),
  .param_err (param_err),
  .total_cnt (total_cnt),
  .budget_q  (budget_lat)
);

// File: tb/code_hist_engine_test.sv
`timescale 1ns/1ps
module code_hist_engine_test;
  localparam int CODE_W = 4;
  localparam int CNT_W  = 32;
  localparam int P_W    = 16;
  localparam int FRAC_W = 8;
  localparam int DNL_W  = 16;
  localparam int NB     = 1 << CODE_W;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic                    start = 1'b0;
  logic [CNT_W-1:0]        budget_m = '0;
  logic [P_W-1:0]          periods_p = '0;
  logic                    ramp_mode = 1'b0;
  logic                    smp_valid = 1'b0;
  logic [CODE_W-1:0]       smp_code = '0;
  logic                    ready, done, param_err;
  logic [CNT_W-1:0]        total_cnt;
  logic                    rd_en = 1'b0;
  logic [CODE_W-1:0]       rd_addr = '0;
  logic                    rd_valid;
  logic [CNT_W-1:0]        rd_count;
  logic                    rd_missing;
  logic signed [DNL_W-1:0] rd_dnl;

  always #4 clk = ~clk;

  code_hist_engine #(.CODE_W(CODE_W), .CNT_W(CNT_W), .P_W(P_W), .FRAC_W(FRAC_W), .DNL_W(DNL_W)) uut (
    .clk(clk), .rst(rst), .start(start), .budget_m(budget_m), .periods_p(periods_p),
    .ramp_mode(ramp_mode), .smp_valid(smp_valid), .smp_code(smp_code), .ready(ready),
    .done(done), .param_err(param_err), .total_cnt(total_cnt), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_count(rd_count), .rd_missing(rd_missing),
    .rd_dnl(rd_dnl)
  );

  typedef struct {
    int     code;
    longint cnt;
    bit     miss;
    longint dnl;
    string  ctag;
    string  dtag;
  } rd_item_t;

  rd_item_t exp_q[$];
  int       errors = 0;
  int       checks = 0;
  longint   model[NB];
  longint   accepted;
  bit       ramp_l;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // monitor: pops expected readouts as the design produces them
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6", "rd_valid without request", 1, 0);
      end else begin
        rd_item_t it;
        it = exp_q.pop_front();
        check(rd_count == it.cnt, it.ctag, $sformatf("count code %0d", it.code), rd_count, it.cnt);
        check(rd_missing == it.miss, "R7", $sformatf("missing code %0d", it.code), rd_missing, it.miss);
        check(rd_dnl == it.dnl, it.dtag, $sformatf("dnl code %0d", it.code), rd_dnl, it.dnl);
      end
    end
  end

  task automatic run_start(input longint m, input int p, input bit ramp);
    budget_m  = CNT_W'(m);
    periods_p = P_W'(p);
    ramp_mode = ramp;
    ramp_l    = ramp;
    start     = 1'b1;
    @(negedge clk);
    start     = 1'b0;
    for (int i = 0; i < NB; i++) model[i] = 0;
    accepted = 0;
  endtask

  task automatic feed(input int code, input bit vld);
    bit r;
    smp_valid = vld;
    smp_code  = CODE_W'(code);
    r = ready;
    @(negedge clk);
    if (vld && r) begin
      model[code]++;
      accepted++;
    end
    smp_valid = 1'b0;
  endtask

  // driver: pushes the expected readout, then issues the request
  task automatic read_code(input int c, input string ctag, input string dtag);
    rd_item_t it;
    longint den, q, d;
    den = accepted - model[0] - model[NB-1];
    d = 0;
    if (ramp_l && c != 0 && c != NB-1 && den != 0) begin
      q = (model[c] * (NB - 2) * (1 << FRAC_W)) / den;
      d = q - (1 << FRAC_W);
      if (d > 32767) d = 32767;
    end
    it.code = c; it.cnt = model[c]; it.miss = (model[c] == 0);
    it.dnl = d; it.ctag = ctag; it.dtag = dtag;
    exp_q.push_back(it);
    rd_en = 1'b1;
    rd_addr = CODE_W'(c);
    @(negedge clk);
    rd_en = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  function automatic int code_for(input int i);
    int c;
    if (i < 6)  return 7;
    if (i < 10) return 0;
    if (i < 13) return NB - 1;
    c = (i * 7) % NB;
    if (c == 5) c = 6;
    return c;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "WD", "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    int i;
    bit seen;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!ready, "R1", "ready after reset", ready, 0);
    check(!done, "R4", "done after reset", done, 0);
    check(total_cnt == 0, "R3", "total after reset", total_cnt, 0);

    // R6: read request before any run is ignored
    rd_en = 1'b1; rd_addr = 3;
    @(negedge clk);
    rd_en = 1'b0;
    seen = 0;
    repeat (60) begin @(negedge clk); if (rd_valid) seen = 1; end
    check(!seen, "R6", "rd_valid while not done", seen, 0);

    // run 1: ramp, M=40, P=3
    run_start(40, 3, 1'b1);
    check(!ready, "R1", "ready low in clear", ready, 0);
    n = 0;
    while (!ready && n < 100) begin @(negedge clk); n++; end
    check(n == NB, "R1", "clear pass length", n, NB);
    check(param_err == 0, "R8", "param_err odd P", param_err, 0);
    i = 0;
    while (accepted < 40) begin
      bit v;
      v = !(i >= 20 && i % 4 == 0);
      feed(v ? code_for(i) : 5, v);   // R11: idle cycles offer code 5
      i++;
    end
    check(!ready, "R4", "ready after final sample", ready, 0);
    check(!done, "R4", "done one cycle late", done, 0);
    feed(5, 1'b1);                    // R11: offered while not ready
    check(done, "R4", "done after drain", done, 1);
    repeat (3) feed(5, 1'b1);
    check(total_cnt == 40, "R3", "total equals budget", total_cnt, 40);
    for (int c = 0; c < NB; c++) read_code(c, (c == 5) ? "R11" : "R2", "R9");

    // run 2: sine, M=0, P=4 (even)
    run_start(0, 4, 1'b0);
    n = 0;
    while (!done && n < 100) begin @(negedge clk); n++; end
    check(n == NB, "R5", "done at end of clear", n, NB);
    check(param_err == 1, "R8", "param_err even P", param_err, 1);
    check(total_cnt == 0, "R3", "total after start", total_cnt, 0);
    read_code(7, "R1", "R9");
    read_code(0, "R5", "R9");
    read_code(NB-1, "R1", "R9");

    // run 3: ramp, M=6, P=3 -> 2P >= M; only end codes -> zero denominator
    run_start(6, 3, 1'b1);
    while (!ready) @(negedge clk);
    check(param_err == 1, "R8", "param_err 2P>=M", param_err, 1);
    feed(0, 1); feed(0, 1); feed(NB-1, 1); feed(0, 1); feed(NB-1, 1); feed(NB-1, 1);
    @(negedge clk);
    check(done, "R4", "done run 3", done, 1);
    read_code(0, "R2", "R10");
    read_code(7, "R2", "R10");
    read_code(NB-1, "R2", "R10");

    // run 4: sine, M=5, P=1, back-to-back same code
    run_start(5, 1, 1'b0);
    while (!ready) @(negedge clk);
    check(param_err == 0, "R8", "param_err ok", param_err, 0);
    repeat (5) feed(3, 1);
    @(negedge clk);
    read_code(3, "R2", "R9");
    read_code(4, "R2", "R9");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule